// File: doc/BRIEF.md
# Alternating On/Off Reload PWM Timer

A single down-counter produces a pulse-width-modulated output by loading two programmable durations in turn. Once enabled, the output goes high and the counter runs through the on duration. At its end the output drops and the counter reloads with the off duration. At the end of that it rises again and reloads the on duration. Each of these phase ends sets a sticky interrupt flag for a host, which clears it with a pulse.

The waveform period is the sum of the two durations, and the duty cycle depends only on them. Between phase ends the timer runs without any host action. New duration values are taken only when a phase begins, so a write never cuts a running phase short or stretches it. Dropping the enable forces the output low and freezes the timer. Raising it again always starts a fresh on phase.

Top module: `pwm_phase_timer`

## Requirements
- R1: One cycle after the first clock edge that samples `en_i` high while the timer is idle, `pwm_o` is 1 and `phase_o` is 1. The on phase lasts max(`on_len_i`,1) cycles.
- R2: After the on phase, `pwm_o` is 0 and `phase_o` is 0 for max(`off_len_i`,1) cycles. Then `pwm_o` returns to 1 for a new on phase, and the two phases alternate for as long as `en_i` stays high.
- R3: A duration value of 0 gives a phase of exactly 1 cycle.
- R4: `irq_o` becomes 1 in the cycle after each phase end, both on-to-off and off-to-on. Starting the timer does not set it.
- R5: `irq_o` stays 1 until a cycle in which `irq_clr_i` is 1 and no phase ends. When a phase end and `irq_clr_i` fall in the same cycle, `irq_o` is 1 afterwards.
- R6: `on_len_i` and `off_len_i` are sampled only at the clock edge that starts a phase. Changing them during a phase leaves that phase's length unchanged, and the next phase uses the new value.
- R7: A clock edge that samples `en_i` low makes `pwm_o` 0 from the next cycle on and holds `phase_o` at its current value while `en_i` stays low.
- R8: Re-enabling after a disable starts a full on phase of max(`on_len_i`,1) cycles, whichever phase was interrupted.
- R9: After reset, `pwm_o` is 0, `irq_o` is 0 and `phase_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| on_len_i | input | 16 | On-phase duration in cycles (0 means 1) |
| off_len_i | input | 16 | Off-phase duration in cycles (0 means 1) |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Sticky phase-end interrupt flag |
| phase_o | output | 1 | Current phase: 1 on, 0 off |

## Verification
A phase end that sets the interrupt flag can fall in the same cycle as a host clear. The bench provokes this by holding `irq_clr_i` high across an on-to-off transition, and it requires the flag to read 1 at that transition and 0 one cycle later. A second collision is a duration write in the middle of a phase. The bench writes new values part way through an on phase and requires the running phase to keep its old length while the following phases use the new values.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  typedef enum logic {
    PH_OFF = 1'b0,
    PH_ON  = 1'b1
  } phase_e;
endpackage

// File: rtl/pwm_down_cnt.sv
module pwm_down_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] start_val;

  // a phase of N cycles counts N-1 .. 0; zero length acts as one
  assign start_val = (len_i == '0) ? '0 : len_i - W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= start_val;
    else if (dec_i)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwm_phase_ctrl.sv
module pwm_phase_ctrl
  import pwm_phase_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   zero_i,
  output logic   start_o,
  output logic   expire_o,
  output logic   dec_o,
  output phase_e phase_o,
  output logic   run_o
);
  logic   run_q;
  phase_e phase_q;

  assign start_o  = en_i & ~run_q;
  assign expire_o = en_i & run_q & zero_i;
  assign dec_o    = en_i & run_q & ~zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      phase_q <= PH_ON;
    end else begin
      run_q <= en_i;
      if (start_o)       phase_q <= PH_ON;
      else if (expire_o) phase_q <= (phase_q == PH_ON) ? PH_OFF : PH_ON;
    end
  end

  assign phase_o = phase_q;
  assign run_o   = run_q;
endmodule

// File: rtl/pwm_irq_flag.sv
module pwm_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer
  import pwm_phase_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LEN_W-1:0] on_len_i,
  input  logic [LEN_W-1:0] off_len_i,
  input  logic             irq_clr_i,
  output logic             pwm_o,
  output logic             irq_o,
  output logic             phase_o
);
  logic             start, expire, dec, zero, run;
  phase_e           phase;
  logic [LEN_W-1:0] next_len;

  pwm_phase_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .zero_i   (zero),
    .start_o  (start),
    .expire_o (expire),
    .dec_o    (dec),
    .phase_o  (phase),
    .run_o    (run)
  );

  // length of the phase about to begin
  always_comb begin
    if (start)               next_len = on_len_i;
    else if (phase == PH_ON) next_len = off_len_i;
    else                     next_len = on_len_i;
  end

  pwm_down_cnt #(.W(LEN_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start | expire),
    .len_i  (next_len),
    .dec_i  (dec),
    .zero_o (zero)
  );

  pwm_irq_flag i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .clr_i  (irq_clr_i),
    .flag_o (irq_o)
  );

  assign pwm_o   = run & (phase == PH_ON);
  assign phase_o = (phase == PH_ON);
endmodule

// File: rtl/pwm_phase_timer_chk.sv
module pwm_phase_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic irq_clr_i,
  input logic pwm_o,
  input logic irq_o,
  input logic phase_o
);
  // R7
  dis_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);

  // R7
  dis_hold_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_o));

  // R4
  fall_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pwm_o) && $past(en_i)) |-> irq_o);

  // R5
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  // R4
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(en_i));

  // R1
  on_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_o |-> phase_o);
endmodule

bind pwm_phase_timer pwm_phase_timer_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .irq_clr_i (irq_clr_i),
  .pwm_o     (pwm_o),
  .irq_o     (irq_o),
  .phase_o   (phase_o)
);

// File: tb/test_pwm_phase_timer.sv
`timescale 1ns/1ps
module test_pwm_phase_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] on_len = '0;
  logic [15:0] off_len = '0;
  logic        irq_clr = 1'b0;
  logic        pwm, irq, phase;
  int          n_run = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  pwm_phase_timer i_pwm_phase_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .on_len_i  (on_len),
    .off_len_i (off_len),
    .irq_clr_i (irq_clr),
    .pwm_o     (pwm),
    .irq_o     (irq),
    .phase_o   (phase)
  );

  // {on, off}
  localparam logic [31:0] VEC [6] = '{
    {16'd3,  16'd5}, {16'd1, 16'd1}, {16'd0, 16'd4},
    {16'd7,  16'd0}, {16'd2, 16'd9}, {16'd10, 16'd3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_lvl(input logic lvl, output int n);
    n = 0;
    while (pwm == lvl && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic int eff(input logic [15:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic restart(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    en = 1'b0; on_len = a; off_len = b; irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0; en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    #35 rst_n = 1'b1;
    @(negedge clk);
    // R9
    check(pwm == 0, "R9 pwm", pwm, 0);
    check(irq == 0, "R9 irq", irq, 0);
    check(phase == 1, "R9 phase", phase, 1);

    // R1 R2 R3 R4 over the vector table
    foreach (VEC[i]) begin
      restart(VEC[i][31:16], VEC[i][15:0]);
      check(pwm == 1 && phase == 1, "R1 start", pwm, 1);
      check(irq == 0, "R4 no irq at start", irq, 0);
      count_lvl(1'b1, n);
      check(n == eff(VEC[i][31:16]), "R1/R3 on length", n, eff(VEC[i][31:16]));
      check(irq == 1, "R4 irq on-to-off", irq, 1);
      count_lvl(1'b0, n);
      check(n == eff(VEC[i][15:0]), "R2/R3 off length", n, eff(VEC[i][15:0]));
    end

    // R4 off-to-on expiry sets irq
    restart(16'd3, 16'd6);
    count_lvl(1'b1, n);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check(irq == 0, "R5 cleared", irq, 0);
    count_lvl(1'b0, n);
    check(irq == 1, "R4 irq off-to-on", irq, 1);

    // R5 set wins over clear, sticky otherwise
    restart(16'd4, 16'd5);
    irq_clr = 1'b1;
    count_lvl(1'b1, n);
    check(irq == 1, "R5 set wins", irq, 1);
    @(negedge clk);
    check(irq == 0, "R5 clear after", irq, 0);
    irq_clr = 1'b0;
    count_lvl(1'b0, n);
    repeat (2) @(negedge clk);
    check(irq == 1, "R5 sticky", irq, 1);

    // R6 mid-phase write
    restart(16'd5, 16'd2);
    @(negedge clk);
    on_len = 16'd9; off_len = 16'd7;
    count_lvl(1'b1, n);
    check(n == 4, "R6 current on kept", n + 1, 5);
    count_lvl(1'b0, n);
    check(n == 7, "R6 new off", n, 7);
    count_lvl(1'b1, n);
    check(n == 9, "R6 new on", n, 9);

    // R7 R8 disable mid on phase
    restart(16'd6, 16'd6);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(pwm == 0, "R7 forced low", pwm, 0);
    repeat (3) @(negedge clk);
    check(pwm == 0 && phase == 1, "R7 held on", phase, 1);
    en = 1'b1;
    @(negedge clk);
    count_lvl(1'b1, n);
    check(n == 6, "R8 full on after re-enable", n, 6);

    // R7 R8 disable in off phase
    repeat (2) @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    check(pwm == 0 && phase == 0, "R7 held off", phase, 0);
    en = 1'b1;
    @(negedge clk);
    check(pwm == 1 && phase == 1, "R8 restarts on", pwm, 1);
    count_lvl(1'b1, n);
    check(n == 6, "R8 on length", n, 6);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule